// File: doc/BRIEF.md
# Source Network-Interface Packet Splitter

This block sits at the injection side of a network interface. It takes one complete packet from the IP-side input queue and emits it into the network as a sequence of flits. Each flit is cut from the packet, starting with the least-significant bits. The flit is released only in a cycle in which the switch allocator grants the request and at least one downstream credit is available.

While a packet is in flight, the block asserts its allocator request every cycle. It refuses new packets until the whole packet has left. One cycle after the last flit leaves, it raises a single-cycle completion pulse toward the input status logic. In the cycle after that pulse it accepts a packet again. A local credit counter tracks how many flits the downstream buffer can still take.

Top module: `pkt_flit_splitter`

## Requirements
- R1: When `pkt_ready` and `pkt_valid` are both high at a clock edge, the packet is captured and `sa_req` is high from the next cycle until the cycle in which the final flit is sent.
- R2: A packet of `PKT_W` bits becomes ceil(`PKT_W`/`FLIT_W`) flits. Flit k carries packet bits [k*`FLIT_W` +: `FLIT_W`], so the lowest slice goes first, and bits above `PKT_W` in the final flit are zero.
- R3: `flit_type` is 2'b01 on the first flit, 2'b10 on the last flit and 2'b00 on any flit between them. A packet that fits in one flit carries 2'b11.
- R4: `flit_valid` is high in exactly those cycles in which `sa_req` is high, `sa_grant` is high and the credit count is non-zero.
- R5: The credit count resets to `CREDITS`. Each sent flit lowers it by one and each `credit_ret` cycle raises it by one. At zero credits no flit leaves, even under a grant.
- R6: `pkt_valid` and `pkt_data` have no effect while `pkt_ready` is low. The packet in flight keeps its flit contents.
- R7: `pkt_done` is a one-cycle pulse in the cycle after the final flit is sent. `pkt_ready` is low during that pulse and high in the following cycle.
- R8: After reset `pkt_ready` is high and `sa_req`, `flit_valid` and `pkt_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet offered by the input queue |
| pkt_data | input | PKT_W | Packet payload |
| pkt_ready | output | 1 | Block idle and able to take a packet |
| sa_grant | input | 1 | Switch-allocator grant for the current request |
| credit_ret | input | 1 | One downstream buffer slot freed |
| sa_req | output | 1 | Switch-allocator request, high while a packet is in flight |
| flit_valid | output | 1 | A flit leaves in this cycle |
| flit_data | output | FLIT_W | Flit payload |
| flit_type | output | 2 | Flit position: 01 head, 00 body, 10 tail, 11 single |
| pkt_done | output | 1 | Completion pulse to the input status logic |

## Verification
The splitter is exercised in three shapes: a packet that needs padding in its last of three flits, a packet that divides evenly into four byte flits, and a packet that fits in a single flit. Together these distinguish errors in slice order, padding and head/tail marking. Random grants and sparse credit returns separate flits released by the grant alone from flits released by the grant and the credit check together. A window with grants held high and no credits returned drains the counter to zero, which shows whether the block stalls correctly. Packets are offered almost every cycle, so any packet captured while one is in flight, or any acceptance during the completion pulse, shows up as corrupted flit data or as a wrong `pkt_ready`.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

   typedef enum logic [1:0] {
      FK_BODY = 2'b00,
      FK_HEAD = 2'b01,
      FK_TAIL = 2'b10,
      FK_SOLO = 2'b11
   } flit_kind_e;

   function automatic int flits_for(input int pkt_bits, input int flit_bits);
      return (pkt_bits + flit_bits - 1) / flit_bits;
   endfunction

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/nif_credit_ctr.sv
module nif_credit_ctr #(
   parameter int CREDITS = 4,
   parameter int CW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] cnt,
   output logic          avail
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CW'(CREDITS);
      end else begin
         case ({take, give})
            2'b10:   cnt <= cnt - 1'b1;
            2'b01:   cnt <= cnt + 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign avail = (cnt != '0);
endmodule

// File: rtl/nif_slice_mux.sv
module nif_slice_mux #(
   parameter int PKT_W  = 40,
   parameter int FLIT_W = 16,
   parameter int NFLIT  = 3,
   parameter int IDX_W  = 2
) (
   input  logic [PKT_W-1:0]  pkt,
   input  logic [IDX_W-1:0]  idx,
   output logic [FLIT_W-1:0] flit
);
   localparam int FULL_W = NFLIT * FLIT_W;

   logic [FULL_W-1:0] padded;
   logic [FLIT_W-1:0] slices [NFLIT];

   generate
      if (FULL_W > PKT_W) begin : g_pad
         assign padded = {{(FULL_W - PKT_W){1'b0}}, pkt};
      end else begin : g_exact
         assign padded = pkt;
      end

      for (genvar s = 0; s < NFLIT; s++) begin : g_slice
         assign slices[s] = padded[s*FLIT_W +: FLIT_W];
      end
   endgenerate

   always_comb begin
      flit = '0;
      for (int i = 0; i < NFLIT; i++) begin
         if (idx == IDX_W'(i)) flit = slices[i];
      end
   end
endmodule

// File: rtl/nif_split_seq.sv
module nif_split_seq
   import splitter_pkg::*;
#(
   parameter int NFLIT = 3,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_valid,
   input  logic             grant,
   input  logic             credit_ok,
   output logic             ready,
   output logic             accept,
   output logic             busy,
   output logic             send,
   output logic [IDX_W-1:0] idx,
   output flit_kind_e       kind,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NFLIT - 1);

   logic busy_q, done_q;
   logic [IDX_W-1:0] idx_q;
   logic last;

   assign ready  = !busy_q && !done_q;
   assign accept = ready && pkt_valid;
   assign send   = busy_q && grant && credit_ok;
   assign last   = (idx_q == LAST);
   assign kind   = flit_kind_e'({last, idx_q == '0});
   assign busy   = busy_q;
   assign idx    = idx_q;
   assign done   = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         done_q <= send && last;
         if (accept) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end else if (send) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pkt_flit_splitter.sv
module pkt_flit_splitter
   import splitter_pkg::*;
#(
   parameter int PKT_W   = 40,
   parameter int FLIT_W  = 16,
   parameter int CREDITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_valid,
   input  logic [PKT_W-1:0]  pkt_data,
   output logic              pkt_ready,
   input  logic              sa_grant,
   input  logic              credit_ret,
   output logic              sa_req,
   output logic              flit_valid,
   output logic [FLIT_W-1:0] flit_data,
   output logic [1:0]        flit_type,
   output logic              pkt_done
);
   localparam int NFLIT = flits_for(PKT_W, FLIT_W);
   localparam int IDX_W = idx_bits(NFLIT);
   localparam int CW    = $clog2(CREDITS + 1);

   generate
      if (!(FLIT_W == 8 || FLIT_W == 16 || FLIT_W == 32)) begin : g_bad_flit
         $error("pkt_flit_splitter: FLIT_W must be 8, 16 or 32");
      end
      if (CREDITS < 1) begin : g_bad_credit
         $error("pkt_flit_splitter: CREDITS must be at least 1");
      end
      if (PKT_W < 1) begin : g_bad_pkt
         $error("pkt_flit_splitter: PKT_W must be positive");
      end
   endgenerate

   logic             accept, send, busy, credit_ok, ready, done;
   logic [IDX_W-1:0] idx;
   logic [CW-1:0]    cred_cnt;
   logic [PKT_W-1:0] pkt_q;
   flit_kind_e       kind;

   always_ff @(posedge clk) begin
      if (!rst_n)      pkt_q <= '0;
      else if (accept) pkt_q <= pkt_data;
   end

   nif_split_seq #(.NFLIT(NFLIT), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_valid (pkt_valid),
      .grant     (sa_grant),
      .credit_ok (credit_ok),
      .ready     (ready),
      .accept    (accept),
      .busy      (busy),
      .send      (send),
      .idx       (idx),
      .kind      (kind),
      .done      (done)
   );

   nif_credit_ctr #(.CREDITS(CREDITS), .CW(CW)) u_cred (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (send),
      .give  (credit_ret),
      .cnt   (cred_cnt),
      .avail (credit_ok)
   );

   nif_slice_mux #(.PKT_W(PKT_W), .FLIT_W(FLIT_W), .NFLIT(NFLIT), .IDX_W(IDX_W)) u_mux (
      .pkt  (pkt_q),
      .idx  (idx),
      .flit (flit_data)
   );

   assign pkt_ready  = ready;
   assign sa_req     = busy;
   assign flit_valid = send;
   assign flit_type  = kind;
   assign pkt_done   = done;
endmodule

// File: rtl/pkt_flit_splitter_chk.sv
module pkt_flit_splitter_chk #(
   parameter int CREDITS = 4,
   parameter int CW      = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pkt_valid,
   input logic          pkt_ready,
   input logic          sa_grant,
   input logic          sa_req,
   input logic          flit_valid,
   input logic [1:0]    flit_type,
   input logic          pkt_done,
   input logic [CW-1:0] cred_cnt
);
   // R1: a captured packet raises the request on the next cycle
   p_req_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_ready && pkt_valid) |=> sa_req);

   // R4: a flit never leaves without request and grant
   p_send_needs_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flit_valid |-> (sa_req && sa_grant));

   // R5: credit counter never drains below zero when a flit leaves, nor exceeds its reset value
   p_send_needs_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flit_valid |-> (cred_cnt != '0));
   p_credit_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cred_cnt <= CW'(CREDITS));

   // R6: no acceptance while a packet is in flight
   p_no_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sa_req |-> !pkt_ready);

   // R7: completion follows a tail flit and lasts one cycle
   p_done_after_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_done) |-> $past(flit_valid && flit_type[1]));
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |=> (!pkt_done && pkt_ready));
endmodule

bind pkt_flit_splitter pkt_flit_splitter_chk #(.CREDITS(CREDITS), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pkt_valid  (pkt_valid),
   .pkt_ready  (pkt_ready),
   .sa_grant   (sa_grant),
   .sa_req     (sa_req),
   .flit_valid (flit_valid),
   .flit_type  (flit_type),
   .pkt_done   (pkt_done),
   .cred_cnt   (cred_cnt)
);

// File: tb/pkt_flit_splitter_test.sv
module split_harness #(
   parameter int PKT_W   = 40,
   parameter int FLIT_W  = 16,
   parameter int CREDITS = 4,
   parameter int SEED    = 1,
   parameter int CYCLES  = 1500
) (
   input  logic clk,
   output int   n_cmp,
   output int   n_bad,
   output logic fin
);
   localparam int NF = (PKT_W + FLIT_W - 1) / FLIT_W;

   logic              rst_n, pkt_valid, sa_grant, credit_ret;
   logic [PKT_W-1:0]  pkt_data;
   logic              pkt_ready, sa_req, flit_valid, pkt_done;
   logic [FLIT_W-1:0] flit_data;
   logic [1:0]        flit_type;

   pkt_flit_splitter #(.PKT_W(PKT_W), .FLIT_W(FLIT_W), .CREDITS(CREDITS)) uut (
      .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
      .pkt_ready(pkt_ready), .sa_grant(sa_grant), .credit_ret(credit_ret),
      .sa_req(sa_req), .flit_valid(flit_valid), .flit_data(flit_data),
      .flit_type(flit_type), .pkt_done(pkt_done)
   );

   // reference model state
   logic [NF*FLIT_W-1:0] m_pkt;
   int   m_idx, m_cred;
   bit   m_busy, m_done;
   bit   e_ready, e_req, e_fv;
   logic [FLIT_W-1:0] e_data;
   logic [1:0] e_type;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (PKT_W=%0d FLIT_W=%0d) t=%0t actual=%0h expected=%0h",
                  tag, PKT_W, FLIT_W, $time, act, exp);
      end
   endtask

   initial begin
      n_cmp = 0; n_bad = 0; fin = 0;
      void'($urandom(SEED));
      rst_n = 0; pkt_valid = 0; sa_grant = 0; credit_ret = 0; pkt_data = '0;
      m_pkt = '0; m_idx = 0; m_cred = CREDITS; m_busy = 0; m_done = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R8 reset pkt_ready", 64'(pkt_ready), 64'd1);
      chk("R8 reset sa_req", 64'(sa_req), 64'd0);
      chk("R8 reset flit_valid", 64'(flit_valid), 64'd0);
      chk("R8 reset pkt_done", 64'(pkt_done), 64'd0);
      rst_n = 1;
      for (int cyc = 0; cyc < CYCLES; cyc++) begin
         bit starve;
         starve     = (cyc >= 300 && cyc < 420);
         pkt_valid  = ($urandom % 10) < 8;
         pkt_data   = PKT_W'({$urandom, $urandom});
         sa_grant   = starve ? 1'b1 : (($urandom % 10) < 6);
         credit_ret = !starve && (m_cred < CREDITS) && (($urandom % 10) < 4);
         #1;
         e_ready = !m_busy && !m_done;
         e_req   = m_busy;
         e_fv    = m_busy && sa_grant && (m_cred > 0);
         e_data  = m_pkt[m_idx*FLIT_W +: FLIT_W];
         e_type  = {m_idx == NF-1, m_idx == 0};
         chk("R1/R6 pkt_ready", 64'(pkt_ready), 64'(e_ready));
         chk("R1 sa_req", 64'(sa_req), 64'(e_req));
         chk("R4/R5 flit_valid", 64'(flit_valid), 64'(e_fv));
         chk("R7 pkt_done", 64'(pkt_done), 64'(m_done));
         if (e_fv) begin
            chk("R2/R6 flit_data", 64'(flit_data), 64'(e_data));
            chk("R3 flit_type", 64'(flit_type), 64'(e_type));
         end
         @(posedge clk);
         m_done = 0;
         if (e_ready && pkt_valid) begin
            m_pkt  = '0;
            m_pkt[PKT_W-1:0] = pkt_data;
            m_busy = 1; m_idx = 0;
         end
         if (e_fv) begin
            m_cred--;
            if (m_idx == NF-1) begin m_busy = 0; m_done = 1; end
            else m_idx++;
         end
         if (credit_ret) m_cred++;
         @(negedge clk);
      end
      fin = 1;
   end
endmodule

module pkt_flit_splitter_test;
   logic clk = 0;
   always #10 clk = ~clk;

   int   c0, b0, c1, b1, c2, b2;
   logic f0, f1, f2;

   split_harness #(.PKT_W(40), .FLIT_W(16), .CREDITS(4), .SEED(11)) h_pad    (.clk(clk), .n_cmp(c0), .n_bad(b0), .fin(f0));
   split_harness #(.PKT_W(32), .FLIT_W(8),  .CREDITS(3), .SEED(23)) h_even   (.clk(clk), .n_cmp(c1), .n_bad(b1), .fin(f1));
   split_harness #(.PKT_W(7),  .FLIT_W(8),  .CREDITS(2), .SEED(37)) h_single (.clk(clk), .n_cmp(c2), .n_bad(b2), .fin(f2));

   initial begin
      int wd_bad;
      wd_bad = 0;
      for (int t = 0; t < 20000; t++) begin
         @(posedge clk);
         if (f0 === 1'b1 && f1 === 1'b1 && f2 === 1'b1) break;
      end
      if (!(f0 === 1'b1 && f1 === 1'b1 && f2 === 1'b1)) begin
         wd_bad = 1;
         $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               c0 + c1 + c2 + wd_bad, b0 + b1 + b2 + wd_bad);
      $finish;
   end
endmodule